// File: doc/BRIEF.md
# Latchable Real-Time Clock Registers

This block keeps wall-clock time inside a larger memory-bank controller. A single-cycle one-hertz enable advances a chain of seconds, minutes, hours and a nine-bit day count. Software sees the time as five byte-wide registers, picked by a three-bit select. It can preset any field by writing to that field's register and can stop the clock with a halt bit.

Time keeps running while software reads it, so a multi-byte read could tear. To avoid this, the block offers a two-step latch port. A write of 0x00 arms the latch, and a later write of 0x01 copies the running counters into a snapshot. From the first capture on, every register read returns the snapshot, which stays frozen until the next capture. Address decoding is left to the surrounding bank controller: it presents the select, the write strobes and the data.

Top module: `rtc_time_keeper`

## Requirements
- R1: After a synchronous reset, every time field, the halt bit and the overflow flag are zero, the latch is disarmed, and no snapshot is held.
- R2: On an enabled tick, seconds count up from 0. The value 59 wraps to 0 and carries into minutes. Minutes also wrap from 59 to 0 and carry into hours.
- R3: Hours wrap from 23 to 0 and carry into the nine-bit day count. Select 3 reads day bits 7..0 and control bit 0 reads day bit 8.
- R4: When the day count wraps from 511 to 0, control bit 7 (overflow) is set. It stays set through later ticks until a control write puts bit 7 to 0.
- R5: Select codes are 0 seconds, 1 minutes, 2 hours, 3 day low byte, 4 control. Selects 5 to 7 read 0xFF, and writes to them change nothing.
- R6: A write to select 0 to 3 loads that field of the running time. A write to select 4 loads day bit 8 from bit 0, halt from bit 6 and overflow from bit 7. A tick arriving in the same cycle as any such write is dropped.
- R7: While control bit 6 (halt) is 1, ticks are ignored and all counters hold. The halt bit always reads its current value.
- R8: A latch-port write of 0x01 while the latch is armed copies the counters into the snapshot. From then on, reads return the snapshot, and the snapshot does not follow later ticks.
- R9: Any latch-port write other than 0x00 disarms the latch. A write of 0x01 with the latch not armed captures nothing.
- R10: Until the first capture after reset, reads return the live counter values. Control bits 5..1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle enable, one per second |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected register value (combinational) |
| latch_wr | input | 1 | Latch-port write strobe |
| latch_wdata | input | 8 | Latch-port write data |

## Verification
The in-RTL properties assume the enable pulse is one cycle wide. They also assume that a strobe on either write port is qualified only by its own data in that cycle, so a held strobe counts as repeated writes. The bench drives every strobe and tick for exactly one clock, changes inputs only on the falling edge, and never overlaps a register write with a tick. The only exception is where the dropped-tick rule is under test. Before each scenario it resets the block, because a capture leaves reads on the snapshot for good.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int DATA_W  = 8;
    localparam int SEL_W   = 3;
    localparam int SEC_W   = 6;
    localparam int MIN_W   = 6;
    localparam int HOUR_W  = 5;
    localparam int DAY_W   = 9;
    localparam int SEC_TOP  = 59;
    localparam int MIN_TOP  = 59;
    localparam int HOUR_TOP = 23;

    localparam int CTL_DAYHI = 0;
    localparam int CTL_HALT  = 6;
    localparam int CTL_OVF   = 7;

    localparam logic [DATA_W-1:0] LATCH_ARM  = 8'h00;
    localparam logic [DATA_W-1:0] LATCH_FIRE = 8'h01;
    localparam logic [DATA_W-1:0] RD_UNUSED  = 8'hFF;

    typedef enum logic [SEL_W-1:0] {
        SEL_SEC   = 3'd0,
        SEL_MIN   = 3'd1,
        SEL_HOUR  = 3'd2,
        SEL_DAYLO = 3'd3,
        SEL_CTRL  = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [SEC_W-1:0]  sec;
        logic [MIN_W-1:0]  min;
        logic [HOUR_W-1:0] hour;
        logic [DAY_W-1:0]  day;
        logic              ovf;
    } time_t;

    function automatic logic sel_valid(input logic [SEL_W-1:0] s);
        return s <= SEL_CTRL;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input logic day_hi,
                                                    input logic halt,
                                                    input logic ovf);
        logic [DATA_W-1:0] v;
        v = '0;
        v[CTL_DAYHI] = day_hi;
        v[CTL_HALT]  = halt;
        v[CTL_OVF]   = ovf;
        return v;
    endfunction

endpackage

// File: rtl/rtc_digit.sv
module rtc_digit #(
    parameter int W   = 6,
    parameter int TOP = 59
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc_in,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] value,
    output logic         carry_out
);
    localparam logic [W-1:0] TOP_V = W'(TOP);

    logic at_top;
    assign at_top    = value >= TOP_V;
    assign carry_out = inc_in && at_top;

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (load) begin
            value <= load_val;
        end else if (inc_in) begin
            value <= at_top ? '0 : value + W'(1);
        end
    end

    // R2: a step below the top adds one
    p_digit_step_r2: assert property (@(posedge clk) disable iff (rst)
        (inc_in && !load && value < TOP_V) |=> value == $past(value) + W'(1));

    // R2/R3: the top value returns to zero
    p_digit_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (inc_in && !load && value >= TOP_V) |=> value == '0);

    // R6: a load wins over counting
    p_digit_load_r6: assert property (@(posedge clk) disable iff (rst)
        load |=> value == $past(load_val));

endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output time_t             live,
    output logic              halt
);
    logic wr_hit, run;
    logic ld_sec, ld_min, ld_hour;
    logic c_sec, c_min, c_hour;
    logic [SEC_W-1:0]  sec_q;
    logic [MIN_W-1:0]  min_q;
    logic [HOUR_W-1:0] hour_q;
    logic [DAY_W-1:0]  day_q;
    logic              ovf_q, halt_q;
    logic              day_full;

    assign wr_hit  = reg_wr && sel_valid(reg_sel);
    assign run     = tick_1hz && !halt_q && !wr_hit;
    assign ld_sec  = wr_hit && reg_sel == SEL_SEC;
    assign ld_min  = wr_hit && reg_sel == SEL_MIN;
    assign ld_hour = wr_hit && reg_sel == SEL_HOUR;
    assign day_full = &day_q;

    rtc_digit #(.W(SEC_W), .TOP(SEC_TOP)) u_sec (
        .clk(clk), .rst(rst), .inc_in(run), .load(ld_sec),
        .load_val(reg_wdata[SEC_W-1:0]), .value(sec_q), .carry_out(c_sec));

    rtc_digit #(.W(MIN_W), .TOP(MIN_TOP)) u_min (
        .clk(clk), .rst(rst), .inc_in(c_sec), .load(ld_min),
        .load_val(reg_wdata[MIN_W-1:0]), .value(min_q), .carry_out(c_min));

    rtc_digit #(.W(HOUR_W), .TOP(HOUR_TOP)) u_hour (
        .clk(clk), .rst(rst), .inc_in(c_min), .load(ld_hour),
        .load_val(reg_wdata[HOUR_W-1:0]), .value(hour_q), .carry_out(c_hour));

    always_ff @(posedge clk) begin
        if (rst) begin
            day_q  <= '0;
            ovf_q  <= 1'b0;
            halt_q <= 1'b0;
        end else if (wr_hit) begin
            if (reg_sel == SEL_DAYLO) begin
                day_q[DATA_W-1:0] <= reg_wdata;
            end else if (reg_sel == SEL_CTRL) begin
                day_q[DAY_W-1] <= reg_wdata[CTL_DAYHI];
                halt_q         <= reg_wdata[CTL_HALT];
                ovf_q          <= reg_wdata[CTL_OVF];
            end
        end else if (c_hour) begin
            day_q <= day_q + DAY_W'(1);
            if (day_full) begin
                ovf_q <= 1'b1;
            end
        end
    end

    always_comb begin
        live.sec  = sec_q;
        live.min  = min_q;
        live.hour = hour_q;
        live.day  = day_q;
        live.ovf  = ovf_q;
    end
    assign halt = halt_q;

    // R7: halted and not written, nothing moves
    p_halt_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (halt_q && !reg_wr) |=> $stable(live));

    // R4: overflow stays set unless software writes control
    p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !(wr_hit && reg_sel == SEL_CTRL)) |=> ovf_q);

    // R4: the day wrap raises the flag
    p_day_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (c_hour && !wr_hit && day_full) |=> (ovf_q && day_q == '0));

    // R6: a write cycle drops the tick for the seconds field
    p_tick_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && reg_sel != SEL_SEC) |=> sec_q == $past(sec_q));

    // R5: a write to an unused select leaves the time alone
    p_unused_sel_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !sel_valid(reg_sel) && !tick_1hz) |=> $stable(live));

endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              latch_wr,
    input  logic [DATA_W-1:0] latch_wdata,
    input  time_t             live,
    output time_t             snap,
    output logic              snap_valid
);
    logic armed, fire;

    assign fire = latch_wr && armed && latch_wdata == LATCH_FIRE;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed      <= 1'b0;
            snap       <= '0;
            snap_valid <= 1'b0;
        end else begin
            if (latch_wr) begin
                armed <= latch_wdata == LATCH_ARM;
            end
            if (fire) begin
                snap       <= live;
                snap_valid <= 1'b1;
            end
        end
    end

    // R8: a capture copies the counters of that cycle
    p_capture_r8: assert property (@(posedge clk) disable iff (rst)
        fire |=> (snap == $past(live) && snap_valid));

    // R9: any non-arming latch write leaves the latch disarmed
    p_disarm_r9: assert property (@(posedge clk) disable iff (rst)
        (latch_wr && latch_wdata != LATCH_ARM) |=> !armed);

    // R8/R9: without a capture the snapshot holds
    p_snap_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(snap));

    // R10: once valid, the snapshot stays valid
    p_valid_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        snap_valid |=> snap_valid);

endmodule

// File: rtl/rtc_time_keeper.sv
module rtc_time_keeper
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              latch_wr,
    input  logic [DATA_W-1:0] latch_wdata
);
    time_t live, snap, src;
    logic  halt, snap_valid;

    rtc_counter u_count (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .reg_sel(reg_sel),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .live(live), .halt(halt));

    rtc_snapshot u_snap (
        .clk(clk), .rst(rst), .latch_wr(latch_wr), .latch_wdata(latch_wdata),
        .live(live), .snap(snap), .snap_valid(snap_valid));

    assign src = snap_valid ? snap : live;

    always_comb begin
        case (reg_sel)
            SEL_SEC:   reg_rdata = DATA_W'(src.sec);
            SEL_MIN:   reg_rdata = DATA_W'(src.min);
            SEL_HOUR:  reg_rdata = DATA_W'(src.hour);
            SEL_DAYLO: reg_rdata = src.day[DATA_W-1:0];
            SEL_CTRL:  reg_rdata = pack_ctrl(src.day[DAY_W-1], halt, src.ovf);
            default:   reg_rdata = RD_UNUSED;
        endcase
    end

    // R5: unused selects read all ones
    p_unused_read_r5: assert property (@(posedge clk) disable iff (rst)
        !sel_valid(reg_sel) |-> reg_rdata == RD_UNUSED);

    // R10: control bits 5..1 read zero
    p_ctrl_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == SEL_CTRL) |-> reg_rdata[5:1] == 5'd0);

endmodule

// File: tb/sim_rtc_time_keeper.sv
module sim_rtc_time_keeper;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1hz = 1'b0;
    logic [2:0] reg_sel = 3'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       latch_wr = 1'b0;
    logic [7:0] latch_wdata = 8'd0;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rtc_time_keeper u0 (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .reg_sel(reg_sel),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .latch_wr(latch_wr), .latch_wdata(latch_wdata));

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_1hz = 1'b1;
            @(negedge clk); tick_1hz = 1'b0;
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic latch(input logic [7:0] d);
        @(negedge clk); latch_wdata = d; latch_wr = 1'b1;
        @(negedge clk); latch_wr = 1'b0;
    endtask

    task automatic expect_reg(input logic [2:0] s, input logic [7:0] exp, input string req);
        @(negedge clk); reg_sel = s; #1;
        checks++;
        if (reg_rdata !== exp) begin
            fails++;
            $display("FAIL %s sel=%0d actual=%h expected=%h", req, s, reg_rdata, exp);
        end
    endtask

    task automatic t_reset();
        do_reset();
        for (int s = 0; s < 5; s++) expect_reg(3'(s), 8'h00, "R1");
    endtask

    task automatic t_sec_min();
        do_reset();
        tick(3);
        expect_reg(3'd0, 8'd3, "R2");
        wr(3'd0, 8'd59);
        tick(1);
        expect_reg(3'd0, 8'd0, "R2");
        expect_reg(3'd1, 8'd1, "R2");
        wr(3'd1, 8'd59); wr(3'd0, 8'd59);
        tick(1);
        expect_reg(3'd1, 8'd0, "R2");
        expect_reg(3'd2, 8'd1, "R2");
    endtask

    task automatic t_hours_days();
        do_reset();
        wr(3'd2, 8'd23); wr(3'd1, 8'd59); wr(3'd0, 8'd59);
        tick(1);
        expect_reg(3'd2, 8'd0, "R3");
        expect_reg(3'd3, 8'd1, "R3");
        wr(3'd3, 8'hFF); wr(3'd2, 8'd23); wr(3'd1, 8'd59); wr(3'd0, 8'd59);
        tick(1);
        expect_reg(3'd3, 8'h00, "R3");
        expect_reg(3'd4, 8'h01, "R3");
    endtask

    task automatic t_overflow();
        do_reset();
        wr(3'd3, 8'hFF); wr(3'd4, 8'h01);
        wr(3'd2, 8'd23); wr(3'd1, 8'd59); wr(3'd0, 8'd59);
        tick(1);
        expect_reg(3'd3, 8'h00, "R4");
        expect_reg(3'd4, 8'h80, "R4");
        tick(2);
        expect_reg(3'd4, 8'h80, "R4");
        wr(3'd4, 8'h00);
        expect_reg(3'd4, 8'h00, "R4");
    endtask

    task automatic t_unused_and_drop();
        do_reset();
        wr(3'd0, 8'd7);
        expect_reg(3'd0, 8'd7, "R6");
        wr(3'd5, 8'h3C);
        expect_reg(3'd5, 8'hFF, "R5");
        expect_reg(3'd7, 8'hFF, "R5");
        expect_reg(3'd0, 8'd7, "R5");
        expect_reg(3'd4, 8'h00, "R5");
        // tick in the same cycle as a minutes write is dropped
        @(negedge clk); reg_sel = 3'd1; reg_wdata = 8'd5; reg_wr = 1'b1; tick_1hz = 1'b1;
        @(negedge clk); reg_wr = 1'b0; tick_1hz = 1'b0;
        expect_reg(3'd0, 8'd7, "R6");
        expect_reg(3'd1, 8'd5, "R6");
    endtask

    task automatic t_halt();
        do_reset();
        wr(3'd0, 8'd20);
        wr(3'd4, 8'h40);
        tick(4);
        expect_reg(3'd0, 8'd20, "R7");
        expect_reg(3'd4, 8'h40, "R7");
        wr(3'd4, 8'h00);
        tick(1);
        expect_reg(3'd0, 8'd21, "R7");
    endtask

    task automatic t_latch();
        do_reset();
        wr(3'd0, 8'd10);
        expect_reg(3'd0, 8'd10, "R10");
        latch(8'h00); latch(8'h01);
        tick(3);
        expect_reg(3'd0, 8'd10, "R8");
        latch(8'h00); latch(8'h01);
        expect_reg(3'd0, 8'd13, "R8");
        tick(1);
        latch(8'h01);
        expect_reg(3'd0, 8'd13, "R9");
        latch(8'h00); latch(8'h05); latch(8'h01);
        expect_reg(3'd0, 8'd13, "R9");
        latch(8'h00); latch(8'h01);
        expect_reg(3'd0, 8'd14, "R8");
        wr(3'd4, 8'h40);
        expect_reg(3'd4, 8'h40, "R7");
    endtask

    initial begin
        t_reset();
        t_sec_min();
        t_hours_days();
        t_overflow();
        t_unused_and_drop();
        t_halt();
        t_latch();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule